// File: doc/BRIEF.md
# Adapter Event Notification Queue

This block holds adapter events that are waiting for the host, and hands them over one at a time, oldest first. Producers push one of two record kinds. An error record carries a function identifier, a function handle, an error detail word, a faulting address and an event code. An availability record carries only the identifier, the handle and the event code. Every push raises a one-cycle attention pulse toward the host, so the host knows to come and collect.

The host asks for a record with a pop request. One cycle later the block presents a response: a result code, a notification type, a content code that tells the two record kinds apart, and the record fields. Fields that an availability record does not carry read as zero. A pop on an empty queue returns a "no event" result code rather than stale data.

The response appears on a wide parallel port. When a parameter enables it, the same response can also be read one byte at a time as a big-endian image.

Top module: `evt_notify_queue`

## Requirements
- R1: After reset `have_event`, `overflow`, `attn` and `rsp_vld` are 0, and every response field reads 0.
- R2: Records leave in the same order they were accepted.
- R3: A pop of an error record gives `rsp_rc`=0, `rsp_nt`=2, `rsp_cc`=1, and all five pushed fields unchanged.
- R4: A pop of an availability record gives `rsp_rc`=0, `rsp_nt`=2 and `rsp_cc`=2, passes through id, handle and code, and returns `rsp_err`=0 and `rsp_addr`=0 whatever was pushed on those inputs.
- R5: A pop on an empty queue gives `rsp_rc`=1, with `rsp_nt`, `rsp_cc` and every field 0. A push in the same cycle does not change that response.
- R6: `rsp_vld` is high for exactly the cycle after each `pop_req`. The response fields change only in that cycle and hold their value until the next pop.
- R7: `attn` is high for exactly the cycle after each cycle in which `push_vld` is high, whether or not the record is stored.
- R8: `have_event` is high exactly when the queue holds at least one record. It reflects each push and pop from the cycle after the clock edge.
- R9: A push while the queue holds DEPTH records, with no pop in the same cycle, is discarded. It sets `overflow`, which stays high until reset.
- R10: A push and a pop in the same cycle on a full queue both take effect. The oldest record is returned, the new record is stored, and `overflow` is unchanged.
- R11: With BYTE_PORT_EN=1, `rd_byte` is byte `rd_idx` of the 24-byte response image {nt, cc, code, fid, fh, err, addr}. Byte 0 is the most significant byte of nt, and each multi-byte field is most significant byte first. For `rd_idx` of 24 or more, `rd_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | Push a record this cycle |
| push_is_err | input | 1 | 1 = error record, 0 = availability record |
| push_fid | input | 32 | Function identifier |
| push_fh | input | 32 | Function handle |
| push_err | input | 32 | Error detail word (error records only) |
| push_addr | input | 64 | Faulting address (error records only) |
| push_code | input | 16 | Event code |
| pop_req | input | 1 | Request the oldest record |
| have_event | output | 1 | Queue not empty |
| overflow | output | 1 | Sticky: a push was discarded |
| attn | output | 1 | One-cycle attention pulse per push |
| rsp_vld | output | 1 | Response updated this cycle |
| rsp_rc | output | 16 | Result code: 0 record returned, 1 no event |
| rsp_nt | output | 8 | Notification type |
| rsp_cc | output | 8 | Content code: 1 error, 2 availability |
| rsp_fid | output | 32 | Function identifier |
| rsp_fh | output | 32 | Function handle |
| rsp_err | output | 32 | Error detail word |
| rsp_addr | output | 64 | Faulting address |
| rsp_code | output | 16 | Event code |
| rd_idx | input | 5 | Byte index into the response image |
| rd_byte | output | 8 | Selected byte of the response image |

## Verification
The bench builds the queue with DEPTH=4 and BYTE_PORT_EN=1. The shallow depth brings the full-queue cases within a few cycles: the discarded push and the sticky overflow flag, and a push and pop in one cycle at the full boundary. A long pseudo-random push/pop phase also reaches them repeatedly. Enabling the byte port lets every one of the 24 image bytes, and the out-of-range indices, be compared after both error and availability pops.

// File: rtl/enq_pkg.sv
package enq_pkg;
  localparam int FID_W  = 32;
  localparam int FH_W   = 32;
  localparam int ERR_W  = 32;
  localparam int ADDR_W = 64;
  localparam int CODE_W = 16;
  localparam int RC_W   = 16;
  localparam int TAG_W  = 8;

  localparam int IMG_BITS  = 2 * TAG_W + CODE_W + FID_W + FH_W + ERR_W + ADDR_W;
  localparam int IMG_BYTES = IMG_BITS / 8;

  localparam logic [RC_W-1:0]  RC_OK     = 16'd0;
  localparam logic [RC_W-1:0]  RC_EMPTY  = 16'd1;
  localparam logic [TAG_W-1:0] NT_EVENT  = 8'd2;
  localparam logic [TAG_W-1:0] CC_ERROR  = 8'd1;
  localparam logic [TAG_W-1:0] CC_AVAIL  = 8'd2;

  typedef struct packed {
    logic              is_err;
    logic [FID_W-1:0]  fid;
    logic [FH_W-1:0]   fh;
    logic [ERR_W-1:0]  detail;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
  } enq_rec_t;

  typedef struct packed {
    logic [RC_W-1:0]   rc;
    logic [TAG_W-1:0]  nt;
    logic [TAG_W-1:0]  cc;
    logic [FID_W-1:0]  fid;
    logic [FH_W-1:0]   fh;
    logic [ERR_W-1:0]  detail;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
  } enq_rsp_t;

  function automatic logic [IMG_BITS-1:0] rsp_image(input enq_rsp_t r);
    return {r.nt, r.cc, r.code, r.fid, r.fh, r.detail, r.addr};
  endfunction
endpackage

// File: rtl/enq_fifo.sv
module enq_fifo
  import enq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_req,
  input  enq_rec_t wr_rec,
  input  logic     rd_req,
  output enq_rec_t head_rec,
  output logic     nonempty,
  output logic     ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  enq_rec_t          mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              do_rd, do_wr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_rd    = rd_req && (cnt_q != '0);
    do_wr    = wr_req && ((cnt_q != CNT_FULL) || do_rd);
    wr_ptr_d = do_wr ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_rd ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_wr && !do_rd)      cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
    ovf_d    = ovf_q || (wr_req && !do_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_rec;
  end

  assign head_rec = mem[rd_ptr_q];
  assign nonempty = (cnt_q != '0);
  assign ovf      = ovf_q;

  // R9: overflow flag is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R9: occupancy never exceeds the depth
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R9: lone push into a full queue is dropped and flagged
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_FULL && wr_req && !rd_req) |=> (ovf_q && cnt_q == CNT_FULL));
  // R10: push with pop on a full queue keeps it full and raises no overflow
  a_r10_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_FULL && wr_req && rd_req && !ovf_q) |=> (cnt_q == CNT_FULL && !ovf_q));
endmodule

// File: rtl/enq_format.sv
module enq_format
  import enq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pop_req,
  input  logic     head_ok,
  input  enq_rec_t head_rec,
  output logic     rsp_vld,
  output enq_rsp_t rsp
);
  enq_rsp_t rsp_q, rsp_d;
  logic     vld_q;

  always_comb begin
    rsp_d = '0;
    if (head_ok) begin
      rsp_d.rc     = RC_OK;
      rsp_d.nt     = NT_EVENT;
      rsp_d.cc     = head_rec.is_err ? CC_ERROR : CC_AVAIL;
      rsp_d.fid    = head_rec.fid;
      rsp_d.fh     = head_rec.fh;
      rsp_d.code   = head_rec.code;
      rsp_d.detail = head_rec.is_err ? head_rec.detail : '0;
      rsp_d.addr   = head_rec.is_err ? head_rec.addr : '0;
    end else begin
      rsp_d.rc     = RC_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      vld_q <= pop_req;
      if (pop_req) rsp_q <= rsp_d;
    end
  end

  assign rsp_vld = vld_q;
  assign rsp     = rsp_q;

  // R4: availability responses carry no address or detail
  a_r4_avail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && rsp_q.cc == CC_AVAIL) |-> (rsp_q.detail == '0 && rsp_q.addr == '0));
  // R5: empty response carries no record content
  a_r5_empty_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && rsp_q.rc != RC_OK) |-> (rsp_q.nt == '0 && rsp_q.cc == '0 && rsp_q.fid == '0));
  // R3: a successful response always has a known content code
  a_r3_cc_known: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && rsp_q.rc == RC_OK) |-> (rsp_q.nt == NT_EVENT && (rsp_q.cc == CC_ERROR || rsp_q.cc == CC_AVAIL)));
  // R6: response holds between pops
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_req |=> ($stable(rsp_q) && !vld_q));
endmodule

// File: rtl/enq_byte_port.sv
module enq_byte_port
  import enq_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  enq_rsp_t   rsp,
  input  logic [4:0] rd_idx,
  output logic [7:0] rd_byte
);
  generate
    if (ENABLE) begin : g_on
      logic [IMG_BITS-1:0] img;
      logic [IMG_BITS-1:0] shifted;
      always_comb begin
        img     = rsp_image(rsp);
        shifted = img << (8 * rd_idx);
        rd_byte = (int'(rd_idx) < IMG_BYTES) ? shifted[IMG_BITS-1 -: 8] : 8'h00;
      end
    end else begin : g_off
      logic unused_inputs;
      assign unused_inputs = ^{rsp, rd_idx};
      assign rd_byte = 8'h00;
    end
  endgenerate
endmodule

// File: rtl/evt_notify_queue.sv
module evt_notify_queue
  import enq_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter bit BYTE_PORT_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_vld,
  input  logic        push_is_err,
  input  logic [31:0] push_fid,
  input  logic [31:0] push_fh,
  input  logic [31:0] push_err,
  input  logic [63:0] push_addr,
  input  logic [15:0] push_code,
  input  logic        pop_req,
  output logic        have_event,
  output logic        overflow,
  output logic        attn,
  output logic        rsp_vld,
  output logic [15:0] rsp_rc,
  output logic [7:0]  rsp_nt,
  output logic [7:0]  rsp_cc,
  output logic [31:0] rsp_fid,
  output logic [31:0] rsp_fh,
  output logic [31:0] rsp_err,
  output logic [63:0] rsp_addr,
  output logic [15:0] rsp_code,
  input  logic [4:0]  rd_idx,
  output logic [7:0]  rd_byte
);
  enq_rec_t in_rec;
  enq_rec_t head_rec;
  enq_rsp_t rsp;
  logic     nonempty;
  logic     attn_q;

  always_comb begin
    in_rec.is_err = push_is_err;
    in_rec.fid    = push_fid;
    in_rec.fh     = push_fh;
    in_rec.detail = push_err;
    in_rec.addr   = push_addr;
    in_rec.code   = push_code;
  end

  enq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (push_vld),
    .wr_rec   (in_rec),
    .rd_req   (pop_req),
    .head_rec (head_rec),
    .nonempty (nonempty),
    .ovf      (overflow)
  );

  enq_format u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_req  (pop_req),
    .head_ok  (nonempty),
    .head_rec (head_rec),
    .rsp_vld  (rsp_vld),
    .rsp      (rsp)
  );

  enq_byte_port #(.ENABLE(BYTE_PORT_EN)) u_bytes (
    .rsp     (rsp),
    .rd_idx  (rd_idx),
    .rd_byte (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attn_q <= 1'b0;
    else        attn_q <= push_vld;
  end

  assign attn       = attn_q;
  assign have_event = nonempty;
  assign rsp_rc     = rsp.rc;
  assign rsp_nt     = rsp.nt;
  assign rsp_cc     = rsp.cc;
  assign rsp_fid    = rsp.fid;
  assign rsp_fh     = rsp.fh;
  assign rsp_err    = rsp.detail;
  assign rsp_addr   = rsp.addr;
  assign rsp_code   = rsp.code;

  // R8: any push leaves at least one record queued
  a_r8_push_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    push_vld |=> have_event);
  // R7: attention follows a push
  a_r7_attn_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    push_vld |=> attn);
  // R5: a pop of an empty queue without a push reports no event
  a_r5_empty_rc: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !have_event) |=> (rsp_vld && rsp_rc == RC_EMPTY));
endmodule

// File: tb/tb_evt_notify_queue.sv
module tb_evt_notify_queue;
  localparam int DEPTH = 4;

  typedef struct {
    bit          e;
    logic [31:0] fid, fh, err;
    logic [63:0] addr;
    logic [15:0] code;
  } mrec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_vld = 0, push_is_err = 0, pop_req = 0;
  logic [31:0] push_fid = 0, push_fh = 0, push_err = 0;
  logic [63:0] push_addr = 0;
  logic [15:0] push_code = 0;
  logic [4:0]  rd_idx = 0;
  logic have_event, overflow, attn, rsp_vld;
  logic [15:0] rsp_rc, rsp_code;
  logic [7:0]  rsp_nt, rsp_cc, rd_byte;
  logic [31:0] rsp_fid, rsp_fh, rsp_err;
  logic [63:0] rsp_addr;

  always #10 clk = ~clk;

  evt_notify_queue #(.DEPTH(DEPTH), .BYTE_PORT_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_is_err(push_is_err),
    .push_fid(push_fid), .push_fh(push_fh), .push_err(push_err),
    .push_addr(push_addr), .push_code(push_code), .pop_req(pop_req),
    .have_event(have_event), .overflow(overflow), .attn(attn), .rsp_vld(rsp_vld),
    .rsp_rc(rsp_rc), .rsp_nt(rsp_nt), .rsp_cc(rsp_cc), .rsp_fid(rsp_fid),
    .rsp_fh(rsp_fh), .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_code(rsp_code),
    .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model
  mrec_t       mq[$];
  logic        e_have, e_ovf, e_attn, e_vld;
  logic [15:0] e_rc, e_code;
  logic [7:0]  e_nt, e_cc;
  logic [31:0] e_fid, e_fh, e_err;
  logic [63:0] e_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      e_have = 0; e_ovf = 0; e_attn = 0; e_vld = 0;
      e_rc = 0; e_nt = 0; e_cc = 0; e_fid = 0; e_fh = 0; e_err = 0; e_addr = 0; e_code = 0;
    end else begin
      e_attn = push_vld;
      e_vld  = pop_req;
      if (pop_req) begin
        if (mq.size() == 0) begin
          e_rc = 1; e_nt = 0; e_cc = 0; e_fid = 0; e_fh = 0; e_err = 0; e_addr = 0; e_code = 0;
        end else begin
          mrec_t r;
          r = mq.pop_front();
          e_rc = 0; e_nt = 2; e_cc = r.e ? 8'd1 : 8'd2;
          e_fid = r.fid; e_fh = r.fh; e_code = r.code;
          e_err  = r.e ? r.err : 32'd0;
          e_addr = r.e ? r.addr : 64'd0;
        end
      end
      if (push_vld) begin
        if (mq.size() < DEPTH) begin
          mrec_t n;
          n.e = push_is_err; n.fid = push_fid; n.fh = push_fh; n.err = push_err;
          n.addr = push_addr; n.code = push_code;
          mq.push_back(n);
        end else e_ovf = 1;
      end
      e_have = (mq.size() != 0);
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8", "have_event", 64'(have_event), 64'(e_have));
      chk("R9", "overflow", 64'(overflow), 64'(e_ovf));
      chk("R7", "attn", 64'(attn), 64'(e_attn));
      chk("R6", "rsp_vld", 64'(rsp_vld), 64'(e_vld));
      chk("R5", "rsp_rc", 64'(rsp_rc), 64'(e_rc));
      chk("R3", "rsp_nt", 64'(rsp_nt), 64'(e_nt));
      chk("R3", "rsp_cc", 64'(rsp_cc), 64'(e_cc));
      chk("R2", "rsp_fid", 64'(rsp_fid), 64'(e_fid));
      chk("R2", "rsp_fh", 64'(rsp_fh), 64'(e_fh));
      chk("R4", "rsp_err", 64'(rsp_err), 64'(e_err));
      chk("R4", "rsp_addr", rsp_addr, e_addr);
      chk("R3", "rsp_code", 64'(rsp_code), 64'(e_code));
    end
  end

  task automatic cyc(input bit ps, input bit pe, input logic [31:0] id,
                     input logic [63:0] ad, input bit pp);
    @(negedge clk);
    push_vld = ps; push_is_err = pe; push_fid = id; push_fh = id ^ 32'h8000_0000;
    push_err = ~id; push_addr = ad; push_code = id[15:0] + 16'h0100;
    pop_req = pp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic byte_sweep();
    logic [191:0] img;
    @(negedge clk);
    push_vld = 0; pop_req = 0;
    img = {e_nt, e_cc, e_code, e_fid, e_fh, e_err, e_addr};
    for (int i = 0; i < 32; i++) begin
      rd_idx = 5'(i);
      #1;
      if (i < 24) chk("R11", "rd_byte", 64'(rd_byte), 64'(img[191 - 8*i -: 8]));
      else        chk("R11", "rd_byte_oob", 64'(rd_byte), 64'h0);
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "have_event", 64'(have_event), 0);
    chk("R1", "overflow", 64'(overflow), 0);
    chk("R1", "attn", 64'(attn), 0);
    chk("R1", "rsp_vld", 64'(rsp_vld), 0);
    chk("R1", "rsp_rc", 64'(rsp_rc), 0);
    chk("R1", "rsp_addr", rsp_addr, 0);
    idle(2);
    // R5: pop on empty
    cyc(0, 0, 0, 0, 1);
    idle(2);
    // R3/R4: error then availability with nonzero unused inputs
    cyc(1, 1, 32'h1111_2222, 64'hDEAD_BEEF_0123_4567, 0);
    cyc(1, 0, 32'h3333_4444, 64'hFFFF_0000_FFFF_0000, 0);
    cyc(0, 0, 0, 0, 1);
    byte_sweep();   // R11 on an error response
    cyc(0, 0, 0, 0, 1);
    byte_sweep();   // R11 on an availability response
    cyc(0, 0, 0, 0, 1);
    byte_sweep();   // R11 on an empty response
    idle(3);        // R6: hold
    // R9: fill, then overflow
    for (int i = 0; i < DEPTH; i++) cyc(1, i[0], 32'h50 + i, 64'h1000 + i, 0);
    cyc(1, 1, 32'hBAD0_0001, 64'hBAD, 0);
    idle(1);
    // R10: push with pop on full
    cyc(1, 0, 32'h6000_0001, 64'h77, 1);
    cyc(1, 1, 32'h6000_0002, 64'h88, 1);
    // R2: drain in order
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 0, 1);
    idle(1);
    // R5: push and pop together on empty
    cyc(1, 1, 32'h7000_0001, 64'h99, 1);
    cyc(0, 0, 0, 0, 1);
    idle(2);
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      cyc(rv[0], rv[1], $urandom, {$urandom, $urandom}, rv[2] & rv[3]);
    end
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 0, 1);
    idle(2);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule